// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block connects a 32-bit memory-mapped register bus to a bank of 64-bit internal registers. Each 64-bit register takes two neighbouring word addresses. The word at the lower address carries bits 63..32. The word four bytes above it carries bits 31..0. Software moves a whole 64-bit value with two ordinary 32-bit accesses, and the bridge keeps each transfer atomic.

On the write side, a store to the upper-bits word only stages the data. A store to the lower-bits word joins the staged half with its own data. It then presents the full 64-bit value on a commit port for one clock, with a one-hot strobe that names the register. After each commit the staging word goes back to zero, so a value whose top half is zero needs just one store.

On the read side, the bridge reads the live 64-bit value of every register from an input port. Reading the upper-bits word samples the whole live value. It returns bits 63..32 and keeps bits 31..0 aside. The next read of the lower-bits word returns that kept half. A free-running counter therefore reads back as a single value and is never split across a carry.

Top module: `split64_bridge`

## Requirements
- R1: After a synchronous active-low reset, `bus_rdata`, `commit_strobe` and `commit_data` are zero, every staging word is zero and no read capture is pending.
- R2: A write to the word at byte offset 0 of a register (address bit 2 = 0) only loads that register's staging word. `commit_strobe` is zero in the following cycle and `commit_data` keeps its previous value.
- R3: A write to the word at byte offset 4 (address bit 2 = 1) of register i sets `commit_strobe` to the one-hot value with bit i in the following cycle, for one cycle only. `commit_data` is then {staging word of i, write data}.
- R4: A commit clears that register's staging word. A write to offset 4 with no write to offset 0 before it commits with bits 63..32 equal to zero.
- R5: Each register has its own staging word. An offset-0 write to one register does not change the value another register commits.
- R6: `bus_rdata` updates in the cycle after a read request and holds its value in every cycle with no read request.
- R7: A read at offset 0 of register i returns bits 63..32 of `live_value` for i, sampled at the request edge. It captures bits 31..0 of that same sample and marks a capture as pending.
- R8: A read at offset 4 of register i with a pending capture returns the captured bits 31..0, whatever the live value is now, and clears the pending mark.
- R9: A read at offset 4 of register i with no pending capture returns the current live bits 31..0.
- R10: A register index (address bits above bit 2) at or beyond NUM_REGS is out of range. A write to it produces no commit, and a read of it returns zero.
- R11: An offset-0 read followed by an offset-4 read of a register whose live value counts up every clock joins into exactly the value the counter held at the first read, including when the low word carries between the two reads.
- R12: Each register has its own capture state. Reads of other registers between the two halves do not disturb a pending capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1..0 ignored, bit 2 picks the half, upper bits pick the register |
| bus_wen | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| commit_strobe | output | NUM_REGS | One-hot pulse naming the register being committed |
| commit_data | output | 64 | Full 64-bit value committed |
| live_value | input | NUM_REGS*64 | Live value of every register, register 0 in the lowest 64 bits |

## Verification
If a staging word is wrong, the bad data shows up only at the next commit of that register, as the top half of `commit_data`. A leftover staged value shows up the same way on a store to offset 4 alone. If the capture state is wrong, the next offset-4 read returns a mix of sampled and live halves. This is visible one cycle after that read, and most clearly on a counting register while its low word carries. The reference model follows staging, capture and read data every clock, so any divergence is flagged on the first cycle it reaches a port.

// File: rtl/bridge_pkg.sv
// Shared types for the split-access 64-bit register bridge.
// Assumes 32-bit bus words and 64-bit internal registers.
package bridge_pkg;
    localparam int WORD_W  = 32;
    localparam int DWORD_W = 2 * WORD_W;

    // Which half of a 64-bit register a bus word addresses (address bit 2).
    typedef enum logic {
        HALF_UPPER = 1'b0,   // lower byte address, bits 63..32
        HALF_LOWER = 1'b1    // byte address + 4, bits 31..0
    } half_e;
endpackage

// File: rtl/bridge_decode.sv
// Address decoder: turns a byte address plus write/read requests into
// one-hot register selects, a half indicator and a read-miss flag.
// Assumes word-aligned accesses; address bits 1..0 are ignored.
module bridge_decode
    import bridge_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wen,
    input  logic                ren,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [NUM_REGS-1:0] rd_sel,
    output half_e               half,
    output logic                rd_miss
);
    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0] idx;
    logic             unused_byte_bits;

    assign idx              = addr[ADDR_W-1:3];
    assign half             = half_e'(addr[2]);
    assign unused_byte_bits = ^addr[1:0];

    // One select line per register, for each request kind.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel[g] = wen && (idx == IDX_W'(g));
        assign rd_sel[g] = ren && (idx == IDX_W'(g));
    end

    // A read whose index names no register returns zero.
    assign rd_miss = ren && (rd_sel == '0);
endmodule

// File: rtl/bridge_wstage.sv
// Write staging for one 64-bit register. An upper-half store loads the
// staging word. A lower-half store fires a commit with {stage, wdata} and
// clears the staging word.
// Assumes at most one store per cycle.
module bridge_wstage
    import bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  half_e              half,
    input  logic [WORD_W-1:0]  wdata,
    output logic               fire,
    output logic [DWORD_W-1:0] joined
);
    logic [WORD_W-1:0] stage_q;

    assign fire   = sel && (half == HALF_LOWER);
    assign joined = {stage_q, wdata};

    // Load the staging word on an upper-half store; clear it on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          stage_q <= '0;
        else if (sel && half == HALF_UPPER)  stage_q <= wdata;
        else if (fire)                       stage_q <= '0;
    end

    // R4: after a commit the staging word is empty
    a_r4_stage_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (stage_q == '0));

    // R5: the staging word only moves when this register is addressed
    a_r5_stage_private: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(stage_q));
endmodule

// File: rtl/bridge_rcapture.sv
// Read path: per-register capture of bits 31..0 on an upper-half read,
// handed back on the next lower-half read of the same register.
// bus_rdata is registered and holds between reads.
// Assumes live values are synchronous to clk.
module bridge_rcapture
    import bridge_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REGS-1:0]         rd_sel,
    input  half_e                       half,
    input  logic                        rd_miss,
    input  logic [NUM_REGS*DWORD_W-1:0] live,
    output logic [WORD_W-1:0]           rdata
);
    logic [NUM_REGS-1:0] pend_q;
    logic [WORD_W-1:0]   hold_q [NUM_REGS];
    logic [DWORD_W-1:0]  sel_live;
    logic [WORD_W-1:0]   sel_hold;
    logic                sel_pend;
    logic [WORD_W-1:0]   rdata_next;

    // Select the live value, held word and pending flag of the addressed register.
    always_comb begin
        sel_live = '0;
        sel_hold = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel[i]) begin
                sel_live = sel_live | live[i*DWORD_W +: DWORD_W];
                sel_hold = sel_hold | hold_q[i];
            end
        end
        sel_pend = |(rd_sel & pend_q);
    end

    // Choose the returned word from the half and the capture state.
    always_comb begin
        if (rd_miss)                 rdata_next = '0;
        else if (half == HALF_UPPER) rdata_next = sel_live[DWORD_W-1:WORD_W];
        else if (sel_pend)           rdata_next = sel_hold;
        else                         rdata_next = sel_live[WORD_W-1:0];
    end

    // Register read data; it only moves on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rdata <= '0;
        else if (rd_miss || |rd_sel)    rdata <= rdata_next;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cap
        // Capture low bits on an upper-half read; release on a lower-half read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
                hold_q[g] <= '0;
            end else if (rd_sel[g] && half == HALF_UPPER) begin
                pend_q[g] <= 1'b1;
                hold_q[g] <= live[g*DWORD_W +: WORD_W];
            end else if (rd_sel[g]) begin
                pend_q[g] <= 1'b0;
            end
        end

        // R7: an upper-half read leaves a capture pending
        a_r7_capture_set: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_sel[g] && half == HALF_UPPER) |=> pend_q[g]);

        // R8: a lower-half read consumes the capture
        a_r8_capture_used: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_sel[g] && half == HALF_LOWER) |=> !pend_q[g]);

        // R12: a capture is untouched by reads of other registers
        a_r12_capture_private: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_sel[g] |=> ($stable(pend_q[g]) && $stable(hold_q[g])));
    end

    // R6: read data holds when there is no read request
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_miss && rd_sel == '0) |=> $stable(rdata));

    // R10: an out-of-range read returns zero
    a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss |=> (rdata == '0));
endmodule

// File: rtl/split64_bridge.sv
// Top level of the split-access 64-bit register bridge. It decodes the
// 32-bit bus, stages and commits writes per register, and serves reads
// with a per-register capture so 64-bit values read back atomically.
// Assumes one bus access per cycle and a synchronous active-low reset.
module split64_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wen,
    input  logic [WORD_W-1:0]           bus_wdata,
    input  logic                        bus_ren,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic [NUM_REGS-1:0]         commit_strobe,
    output logic [DWORD_W-1:0]          commit_data,
    input  logic [NUM_REGS*DWORD_W-1:0] live_value
);
    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] rd_sel;
    half_e               half;
    logic                rd_miss;
    logic [NUM_REGS-1:0] fire;
    logic [DWORD_W-1:0]  joined [NUM_REGS];
    logic [DWORD_W-1:0]  commit_next;

    bridge_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_decode (
        .addr    (bus_addr),
        .wen     (bus_wen),
        .ren     (bus_ren),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .half    (half),
        .rd_miss (rd_miss)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stage
        bridge_wstage i_wstage (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (wr_sel[g]),
            .half   (half),
            .wdata  (bus_wdata),
            .fire   (fire[g]),
            .joined (joined[g])
        );
    end

    // Pick the joined value of the register being committed.
    always_comb begin
        commit_next = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (fire[i]) commit_next = commit_next | joined[i];
    end

    // Register the commit strobe each cycle and the data on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_strobe <= '0;
            commit_data   <= '0;
        end else begin
            commit_strobe <= fire;
            if (|fire) commit_data <= commit_next;
        end
    end

    bridge_rcapture #(.NUM_REGS(NUM_REGS)) i_rcapture (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (rd_sel),
        .half    (half),
        .rd_miss (rd_miss),
        .live    (live_value),
        .rdata   (bus_rdata)
    );

    // R3: at most one register commits per cycle
    a_r3_commit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_strobe));

    // R2: an upper-half store never commits
    a_r2_upper_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && half == HALF_UPPER) |=> (commit_strobe == '0));

    // R2: commit data holds when nothing commits
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fire == '0) |=> $stable(commit_data));
endmodule

// File: tb/test_split64_bridge.sv
module test_split64_bridge;
    localparam int ADDR_W = 6;
    localparam int NREG   = 4;
    localparam logic [63:0] CNT_START = 64'h0000_0007_FFFF_FFF4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wen = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ren = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NREG-1:0]   commit_strobe;
    logic [63:0]       commit_data;
    logic [NREG*64-1:0] live_value;

    logic [63:0] cnt;
    logic        cnt_load = 1'b0;
    logic [63:0] live1 = 64'h0, live2 = 64'h0, live3 = 64'h0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_stage [NREG];
    logic [31:0] m_hold  [NREG];
    bit          m_pend  [NREG];
    logic [31:0] m_rdata;
    logic [NREG-1:0] m_strobe;
    logic [63:0] m_cdata;

    always #2 clk = ~clk;  // 250 MHz

    assign live_value = {live3, live2, live1, cnt};

    split64_bridge #(.ADDR_W(ADDR_W), .NUM_REGS(NREG)) i_split64_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
        .commit_strobe(commit_strobe), .commit_data(commit_data),
        .live_value(live_value)
    );

    always @(posedge clk) begin
        if (!rst_n || cnt_load) cnt <= CNT_START;
        else                    cnt <= cnt + 64'd1;
    end

    function automatic logic [63:0] live_of(int i);
        case (i)
            0: return cnt;
            1: return live1;
            2: return live2;
            default: return live3;
        endcase
    endfunction

    // behavioural reference model, updated at every edge
    always @(posedge clk) begin
        int idx;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                m_stage[i] = 0; m_hold[i] = 0; m_pend[i] = 0;
            end
            m_rdata = 0; m_strobe = 0; m_cdata = 0;
        end else begin
            idx = int'(bus_addr >> 3);
            m_strobe = 0;
            if (bus_wen && idx < NREG) begin
                if (!bus_addr[2]) m_stage[idx] = bus_wdata;
                else begin
                    m_strobe[idx] = 1'b1;
                    m_cdata = {m_stage[idx], bus_wdata};
                    m_stage[idx] = 0;
                end
            end
            if (bus_ren) begin
                if (idx >= NREG) m_rdata = 0;
                else if (!bus_addr[2]) begin
                    m_rdata = live_of(idx) >> 32;
                    m_hold[idx] = live_of(idx);
                    m_pend[idx] = 1;
                end else if (m_pend[idx]) begin
                    m_rdata = m_hold[idx];
                    m_pend[idx] = 0;
                end else m_rdata = live_of(idx);
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare against the model every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "rdata", 64'(bus_rdata), 64'(m_rdata));
            chk(cur_req, "strobe", 64'(commit_strobe), 64'(m_strobe));
            chk(cur_req, "commit_data", commit_data, m_cdata);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        @(negedge clk);
        bus_ren = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] d, hi, lo;
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rdata", 64'(bus_rdata), 0);
        chk("R1", "strobe", 64'(commit_strobe), 0);
        chk("R1", "commit_data", commit_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: first store with nothing staged
        cur_req = "R4";
        wr(6'h0C, 32'h0000_1111);
        chk("R4", "commit_data", commit_data, 64'h0000_0000_0000_1111);

        cur_req = "R2";
        wr(6'h08, 32'hAAAA_0001);
        chk("R2", "strobe", 64'(commit_strobe), 0);
        chk("R2", "commit_data held", commit_data, 64'h0000_0000_0000_1111);

        cur_req = "R3";
        wr(6'h0C, 32'h5555_0002);
        chk("R3", "strobe", 64'(commit_strobe), 64'h2);
        chk("R3", "commit_data", commit_data, 64'hAAAA_0001_5555_0002);
        @(negedge clk);
        chk("R3", "strobe pulse ends", 64'(commit_strobe), 0);

        cur_req = "R4";
        wr(6'h0C, 32'h0000_1234);
        chk("R4", "stage cleared", commit_data, 64'h0000_0000_0000_1234);

        cur_req = "R5";
        wr(6'h10, 32'h0000_BEEF);
        wr(6'h18, 32'h0000_CAFE);
        wr(6'h14, 32'h0000_0001);
        chk("R5", "reg2 commit", commit_data, 64'h0000_BEEF_0000_0001);
        wr(6'h1C, 32'h0000_0003);
        chk("R5", "reg3 commit", commit_data, 64'h0000_CAFE_0000_0003);
        chk("R5", "reg3 strobe", 64'(commit_strobe), 64'h8);

        cur_req = "R10";
        wr(6'h10, 32'h7777_7777);
        wr(6'h24, 32'h0000_0009);
        chk("R10", "no commit", 64'(commit_strobe), 0);
        wr(6'h14, 32'h0000_0005);
        chk("R10", "stage intact", commit_data, 64'h7777_7777_0000_0005);
        live2 = 64'h1111_2222_3333_4444;
        rd(6'h10, d);
        rd(6'h20, d);
        chk("R10", "miss reads zero", 64'(d), 0);

        cur_req = "R7";
        rd(6'h10, d);
        chk("R7", "upper", 64'(d), 64'h1111_2222);
        live2 = 64'h9999_8888_7777_6666;
        cur_req = "R6";
        repeat (3) @(negedge clk);
        chk("R6", "rdata held", 64'(bus_rdata), 64'h1111_2222);
        cur_req = "R8";
        rd(6'h14, d);
        chk("R8", "held lower", 64'(d), 64'h3333_4444);
        cur_req = "R9";
        rd(6'h14, d);
        chk("R9", "live lower", 64'(d), 64'h7777_6666);

        cur_req = "R12";
        live1 = 64'hA1A1_A1A1_B1B1_B1B1;
        live3 = 64'hC3C3_C3C3_D3D3_D3D3;
        rd(6'h08, d);
        rd(6'h18, d);
        live1 = 64'h0;
        live3 = 64'h0;
        rd(6'h14, d);
        chk("R12", "reg2 no capture", 64'(d), 64'h7777_6666);
        rd(6'h0C, d);
        chk("R12", "reg1 held", 64'(d), 64'hB1B1_B1B1);
        rd(6'h1C, d);
        chk("R12", "reg3 held", 64'(d), 64'hD3D3_D3D3);

        // R11: counter read across a low-word carry, varying gaps
        cur_req = "R11";
        @(negedge clk);
        cnt_load = 1'b1;
        @(negedge clk);
        cnt_load = 1'b0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            snap = cnt;
            bus_addr = 6'h00; bus_ren = 1'b1;
            @(negedge clk);
            bus_ren = 1'b0;
            hi = bus_rdata;
            repeat (t % 3) @(negedge clk);
            rd(6'h04, lo);
            chk("R11", "joined counter", {hi, lo}, snap);
        end

        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rdata after reset", 64'(bus_rdata), 0);
        rst_n = 1'b1;
        rd(6'h0C, d);
        chk("R1", "no pending after reset", 64'(d), 64'h0);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule